// File: doc/BRIEF.md
# Dual Phase-Correct PWM Generator

This block runs a timer as an up/down counter. The counter climbs from zero to a ceiling chosen by a resolution select, turns, and falls back to zero. It repeats this for as long as its count enable is asserted. Two channels watch the count. Each channel has its own compare value and its own two-bit output mode. The output pin of each channel changes level only where the count meets that channel's compare value. The pulse therefore stays centred on the zero point of the count, and its width follows the compare value.

The compare inputs act as a write buffer. A channel copies its compare input into its working compare only on the step at which the count reaches the ceiling. A new duty value therefore never lands partway through a half-period. Only the low ten bits of a compare input are used. The count enable comes from an external prescaler. Every counter and channel update happens on a clock edge where that enable is high.

Top module: `dpwm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count reads 0 and both pins read 0. The working compare values reset to 0.
- R2: On each clock with `tick_en` high, the count moves by exactly one. It rises from 0 to TOP, falls from TOP to 0, and repeats. With `tick_en` low, the count and the internal pin levels hold their values.
- R3: TOP is set by `res_sel`: 2'b00 gives 255, 2'b01 gives 511, and 2'b10 or 2'b11 give 1023. With `tick_en` held high, one full period lasts 2*TOP clocks (510, 1022 or 2046).
- R4: Only bits [9:0] of `cmp_a` and `cmp_b` take part. Bits [15:10] have no effect on either pin.
- R5: A channel copies its compare input into its working compare only on the tick that brings the count to TOP. A change on the compare input at any other time has no effect on the pin until that point.
- R6: In mode 2'b10, a pin goes low when a rising step reaches the working compare value C, and goes high when a falling step reaches C. For 0 < C < TOP, the pin is high for 2*C clocks of each period.
- R7: In mode 2'b11, the pin is the complement of the mode 2'b10 waveform: it is high for 2*(TOP-C) clocks of each period.
- R8: In modes 2'b00 and 2'b01, the pin is disconnected and reads 0. A mode change shows on the pin at the next clock edge.
- R9: A working compare of 0 holds the mode 2'b10 pin low for the whole period. A working compare at or above TOP holds it high for the whole period.
- R10: The two channels are independent. Each pin depends only on the shared count and on its own compare input and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer count enable from the prescaler |
| res_sel | input | 2 | Resolution select: 8, 9 or 10 bits |
| cmp_a | input | 16 | Compare input, channel A (low 10 bits used) |
| cmp_b | input | 16 | Compare input, channel B (low 10 bits used) |
| mode_a | input | 2 | Output mode, channel A |
| mode_b | input | 2 | Output mode, channel B |
| cnt_o | output | 10 | Current count |
| pwm_a | output | 1 | PWM pin, channel A |
| pwm_b | output | 1 | PWM pin, channel B |

## Verification
The bench builds the block with its default parameters: an 8-bit base width, three resolutions and 16-bit compare inputs. These settings make all three ceilings reachable, so periods of 510, 1022 and 2046 clocks each fit many times into the run. The 16-bit compare inputs leave six upper bits that must be ignored, so R4 can be exercised. The short 8-bit period allows mid-period compare changes, the extreme compare values and every mode to be tried over whole periods. Sparse enables and a held enable are also tried.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int unsigned DEF_BASE_W  = 8;
  localparam int unsigned DEF_NUM_RES = 3;
  localparam int unsigned DEF_CMP_W   = 16;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'b00,
    PIN_SPARE  = 2'b01,
    PIN_NONINV = 2'b10,
    PIN_INV    = 2'b11
  } pin_mode_e;

  // Ceiling of the count for a resolution index; out-of-range selects
  // fall back to the widest resolution.
  function automatic int unsigned top_of(int unsigned sel,
                                         int unsigned base_w,
                                         int unsigned num_res);
    int unsigned r;
    r = (sel >= num_res) ? (num_res - 1) : sel;
    return (32'd1 << (base_w + r)) - 32'd1;
  endfunction

  // Non-inverted pin level after a step that landed on cnt, moving in
  // the direction given by rising, against working compare cmp.
  function automatic logic level_of(int unsigned cnt,
                                    logic        rising,
                                    int unsigned cmp,
                                    int unsigned top);
    if (cmp == 0)   return 1'b0;
    if (cmp >= top) return 1'b1;
    if (rising)     return (cnt < cmp);
    return (cnt <= cmp);
  endfunction

  // Pin value for an output mode and a non-inverted level.
  function automatic logic pin_of(logic [1:0] mode, logic lvl);
    case (pin_mode_e'(mode))
      PIN_NONINV: return lvl;
      PIN_INV:    return !lvl;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter
  import dpwm_pkg::*;
#(
  parameter int unsigned BASE_W  = DEF_BASE_W,
  parameter int unsigned NUM_RES = DEF_NUM_RES,
  localparam int unsigned CNT_W  = BASE_W + NUM_RES - 1,
  localparam int unsigned SEL_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] res_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] next_cnt,
  output logic [CNT_W-1:0] top,
  output logic             step_rise,
  output logic             at_top
);

  logic up_q;
  logic up_d;
  logic turn_down;

  assign top = CNT_W'(top_of(32'(res_sel), BASE_W, NUM_RES));

  // A count at or above the ceiling (after a resolution change) always
  // steps downward.
  always_comb begin
    turn_down = !up_q || (cnt_q >= top);
    step_rise = !turn_down;
    if (turn_down) begin
      next_cnt = cnt_q - CNT_W'(1);
      up_d     = (next_cnt == '0);
    end else begin
      next_cnt = cnt_q + CNT_W'(1);
      up_d     = (next_cnt < top);
    end
  end

  assign at_top = tick && (next_cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= next_cnt;
      up_q  <= up_d;
    end
  end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_BASE_W + DEF_NUM_RES - 1,
  parameter int unsigned CMP_W = DEF_CMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] next_cnt,
  input  logic             step_rise,
  input  logic [CNT_W-1:0] top,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] act_q,
  output logic             lvl_q,
  output logic             pin_q
);

  logic [CNT_W-1:0] act_d;
  logic             lvl_d;
  logic             pin_d;

  // Working compare is refreshed only at the ceiling, from the low bits.
  assign act_d = load ? cmp_in[CNT_W-1:0] : act_q;

  always_comb begin
    if (tick)
      lvl_d = level_of(32'(next_cnt), step_rise, 32'(act_d), 32'(top));
    else
      lvl_d = lvl_q;
    pin_d = pin_of(mode, lvl_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      lvl_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      act_q <= act_d;
      lvl_q <= lvl_d;
      pin_q <= pin_d;
    end
  end

endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int unsigned BASE_W  = DEF_BASE_W,
  parameter int unsigned NUM_RES = DEF_NUM_RES,
  parameter int unsigned CMP_W   = DEF_CMP_W,
  localparam int unsigned CNT_W  = BASE_W + NUM_RES - 1,
  localparam int unsigned SEL_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
  localparam int unsigned NUM_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] res_sel,
  input  logic [CMP_W-1:0] cmp_a,
  input  logic [CMP_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_a,
  output logic             pwm_b
);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]              next_cnt;
  logic [CNT_W-1:0]              top;
  logic                          step_rise;
  logic                          at_top;
  logic [NUM_CH-1:0][CMP_W-1:0]  cmp_vec;
  logic [NUM_CH-1:0][1:0]        mode_vec;
  logic [NUM_CH-1:0][CNT_W-1:0]  act_q;
  logic [NUM_CH-1:0]             lvl_q;
  logic [NUM_CH-1:0]             pin_q;

  assign cmp_vec  = {cmp_b, cmp_a};
  assign mode_vec = {mode_b, mode_a};

  dpwm_counter #(
    .BASE_W  (BASE_W),
    .NUM_RES (NUM_RES)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .res_sel   (res_sel),
    .cnt_q     (cnt_o),
    .next_cnt  (next_cnt),
    .top       (top),
    .step_rise (step_rise),
    .at_top    (at_top)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dpwm_channel #(
      .CNT_W (CNT_W),
      .CMP_W (CMP_W)
    ) u_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .load      (at_top),
      .next_cnt  (next_cnt),
      .step_rise (step_rise),
      .top       (top),
      .cmp_in    (cmp_vec[ch]),
      .mode      (mode_vec[ch]),
      .act_q     (act_q[ch]),
      .lvl_q     (lvl_q[ch]),
      .pin_q     (pin_q[ch])
    );
  end

  assign pwm_a = pin_q[0];
  assign pwm_b = pin_q[1];

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned CMP_W  = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick_en,
  input logic [SEL_W-1:0]             res_sel,
  input logic [CMP_W-1:0]             cmp_a,
  input logic [CMP_W-1:0]             cmp_b,
  input logic [1:0]                   mode_a,
  input logic [1:0]                   mode_b,
  input logic [CNT_W-1:0]             cnt_o,
  input logic                         pwm_a,
  input logic                         pwm_b,
  input logic                         step_rise,
  input logic                         at_top,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_q,
  input logic [NUM_CH-1:0]            lvl_q
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
  logic [CNT_W:0] cnt_x;
  assign cnt_x = {1'b0, cnt_o};

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> ((cnt_x == $past(cnt_x) + ONE) || (cnt_x + ONE == $past(cnt_x))));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt_o) && $stable(lvl_q)));

  a_r3_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (!$stable(res_sel) || !step_rise));

  a_r5_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (act_q[0] == $past(cmp_a[CNT_W-1:0])));

  a_r5_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (act_q[1] == $past(cmp_b[CNT_W-1:0])));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !at_top |=> $stable(act_q));

  a_r6_noninv_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 2'b10) |=> (pwm_a == lvl_q[0]));

  a_r7_inv_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'b11) |=> (pwm_b != lvl_q[1]));

  a_r8_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_a[1] |=> !pwm_a);

  a_r8_off_b: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_b[1] |=> !pwm_b);

  a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !at_top && (act_q[0] == '0)) |=> !lvl_q[0]);

endmodule

bind dpwm_top dpwm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .res_sel   (res_sel),
  .cmp_a     (cmp_a),
  .cmp_b     (cmp_b),
  .mode_a    (mode_a),
  .mode_b    (mode_b),
  .cnt_o     (cnt_o),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .step_rise (step_rise),
  .at_top    (at_top),
  .act_q     (act_q),
  .lvl_q     (lvl_q)
);

// File: tb/dpwm_top_bench.sv
`timescale 1ns/1ps
module dpwm_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  res_sel = 2'b00;
  logic [15:0] cmp_a = '0;
  logic [15:0] cmp_b = '0;
  logic [1:0]  mode_a = 2'b00;
  logic [1:0]  mode_b = 2'b00;
  logic [9:0]  cnt_o;
  logic        pwm_a;
  logic        pwm_b;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dpwm_top u_dpwm_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .res_sel (res_sel),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .mode_a  (mode_a),
    .mode_b  (mode_b),
    .cnt_o   (cnt_o),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_top(int sel);
    if (sel == 0) return 255;
    if (sel == 1) return 511;
    return 1023;
  endfunction

  function automatic string mode_req(logic [1:0] m);
    if (m == 2'b10) return "R6";
    if (m == 2'b11) return "R7";
    return "R8";
  endfunction

  // Behavioural reference: a counter with a direction flag, set/clear
  // events on the compare match, and the pin picked by the mode.
  int m_cnt = 0;
  bit m_up = 1;
  int m_ocr [2] = '{0, 0};
  bit m_lvl [2] = '{0, 0};
  bit m_pin [2] = '{0, 0};

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_up = 1;
      m_ocr = '{0, 0}; m_lvl = '{0, 0}; m_pin = '{0, 0};
    end else begin
      int top;
      bit rise;
      logic [1:0] md [2];
      top = exp_top(int'(res_sel));
      md[0] = mode_a; md[1] = mode_b;
      if (tick_en) begin
        if (m_up && m_cnt < top) begin
          m_cnt++; rise = 1;
          if (m_cnt == top) m_up = 0;
        end else begin
          m_cnt--; rise = 0;
          if (m_cnt == 0) m_up = 1;
        end
        if (m_cnt == top) begin
          m_ocr[0] = int'(cmp_a) % 1024;
          m_ocr[1] = int'(cmp_b) % 1024;
        end
        for (int c = 0; c < 2; c++) begin
          if (m_ocr[c] == 0)          m_lvl[c] = 0;
          else if (m_ocr[c] >= top)   m_lvl[c] = 1;
          else if (m_cnt == top)      m_lvl[c] = 0;
          else if (m_cnt == m_ocr[c]) m_lvl[c] = !rise;
        end
      end
      for (int c = 0; c < 2; c++)
        m_pin[c] = (md[c] == 2'b10) ? m_lvl[c] : (md[c] == 2'b11) ? !m_lvl[c] : 1'b0;
    end
    #5;
    chk("R2", "count vs model", int'(cnt_o), m_cnt);
    chk(mode_req(mode_a), "pwm_a vs model", int'(pwm_a), int'(m_pin[0]));
    chk(mode_req(mode_b), "pwm_b vs model", int'(pwm_b), int'(m_pin[1]));
  end

  task automatic sample();
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset(logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    tick_en = 1'b0;
    res_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Aligns on an arrival at the ceiling, then counts one full period.
  task automatic measure(output int len, output int ha, output int hb);
    int top;
    top = exp_top(int'(res_sel));
    do sample(); while (int'(cnt_o) != top);
    len = 0; ha = 0; hb = 0;
    do begin
      sample();
      len++;
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end while (int'(cnt_o) != top);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, ha, hb, held;

    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "count in reset", int'(cnt_o), 0);
    chk("R1", "pins in reset", int'({pwm_a, pwm_b}), 0);
    do_reset(2'b00);
    sample();
    chk("R1", "count after release", int'(cnt_o), 0);
    chk("R1", "pins after release", int'({pwm_a, pwm_b}), 0);

    // R3/R6/R7/R4/R10: 8-bit, two different channels
    @(negedge clk);
    tick_en = 1'b1;
    mode_a = 2'b10; cmp_a = 16'd100;
    mode_b = 2'b11; cmp_b = 16'hFC40;
    measure(len, ha, hb);
    chk("R3", "8-bit period", len, 510);
    chk("R6", "noninv high clocks", ha, 200);
    chk("R7", "inv high clocks (R4 low bits 64)", hb, 510 - 128);
    chk("R10", "channel A untouched by B", ha, 200);

    // R9: extremes
    @(negedge clk);
    cmp_a = 16'd0;
    mode_b = 2'b10; cmp_b = 16'd255;
    measure(len, ha, hb);
    chk("R9", "compare 0 high clocks", ha, 0);
    chk("R9", "compare TOP high clocks", hb, 510);

    // R5: mid-period change waits for the ceiling
    @(negedge clk);
    cmp_a = 16'd30;
    measure(len, ha, hb);
    chk("R5", "compare 30 high clocks", ha, 60);
    @(negedge clk);
    cmp_a = 16'd200;
    do sample(); while (cnt_o != 10'd0);
    do sample(); while (cnt_o != 10'd100);
    chk("R5", "old compare still in use", int'(pwm_a), 0);
    measure(len, ha, hb);
    chk("R5", "new compare after ceiling", ha, 400);

    // R8: disconnected modes, next-edge effect
    @(negedge clk);
    mode_a = 2'b00; mode_b = 2'b01;
    cmp_a = 16'd100; cmp_b = 16'd100;
    sample();
    chk("R8", "mode 00 next edge", int'(pwm_a), 0);
    measure(len, ha, hb);
    chk("R8", "mode 00 high clocks", ha, 0);
    chk("R8", "mode 01 high clocks", hb, 0);

    // R2: hold with enable low, then sparse enable
    @(negedge clk);
    mode_a = 2'b10; mode_b = 2'b11;
    do sample(); while (cnt_o != 10'd77);
    @(negedge clk);
    tick_en = 1'b0;
    sample();
    held = int'(cnt_o);
    repeat (40) sample();
    chk("R2", "count held without enable", int'(cnt_o), held);
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      tick_en = (i % 3) != 0;
    end
    @(negedge clk);
    tick_en = 1'b1;

    // R3: 9-bit
    do_reset(2'b01);
    @(negedge clk);
    tick_en = 1'b1;
    mode_a = 2'b10; cmp_a = 16'd300;
    mode_b = 2'b11; cmp_b = 16'd100;
    measure(len, ha, hb);
    chk("R3", "9-bit period", len, 1022);
    chk("R6", "9-bit noninv high clocks", ha, 600);
    chk("R7", "9-bit inv high clocks", hb, 1022 - 200);

    // R3: select 11 acts as 10-bit; R4 with all-ones upper bits
    do_reset(2'b11);
    @(negedge clk);
    tick_en = 1'b1;
    mode_a = 2'b10; cmp_a = 16'hFFFF;
    mode_b = 2'b10; cmp_b = 16'd700;
    measure(len, ha, hb);
    chk("R3", "10-bit period", len, 2046);
    chk("R9", "10-bit full compare high clocks", ha, 2046);
    chk("R4", "10-bit compare 700 high clocks", hb, 1400);

    repeat (5) sample();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule